// File: doc/BRIEF.md
# Shared Interrupt Source Controller

The block gathers a bank of external interrupt lines and turns them into per-processor pending vectors and per-processor interrupt pins. Every line has its own sense setting (level or edge, active-high or active-low, optionally both edges), its own enable bit, its own target processor and its own output pin. Software configures it through a simple write/read register port. Enable bits are changed by writing a source index to a set address or a clear address, so no read-modify-write is ever needed.

Edge-sensed sources latch until software acknowledges them through the edge command address. The same address also lets software raise an edge on a source by itself. Level-sensed sources simply follow their polarity-corrected synchronized input. Each processor's pin outputs are the OR of all sources that are pending, enabled, aimed at that processor and aimed at that pin.

Top module: `shint_ctrl`

## Requirements
- R1: After reset every source is disabled, level-sensed and active-high (sense read value 1). All pending words, enable words, `vp_pend` and `irq_out` read zero. Every source is aimed at processor 0 with pin delivery off.
- R2: A level source (sense bit1 = 0) is pending while its synchronized input equals its polarity bit (sense bit0: 1 = high, 0 = low). Pending shows two clocks after the input changes.
- R3: An edge source (sense bit1 = 1, bit2 = 0) latches on a rising input edge when bit0 = 1 and on a falling edge when bit0 = 0. The latch stays set after the input returns.
- R4: With sense bit2 = 1 and bit1 = 1, either input edge latches the source, whatever the polarity bit holds.
- R5: Writing the edge command address (0x03) with bit31 = 0 and a source index clears that source's latch. Writing a source's sense register (0x20 + index) also clears its latch.
- R6: Writing 0x03 with bit31 = 1 and an index sets the latch of an edge source on the next clock. On a level source this write has no effect.
- R7: Writing an index to 0x01 enables that source only, and writing an index to 0x02 disables it only. An index ≥ the source count changes nothing. Enable bits read back as words at 0x18 + word. No processor sees a disabled source.
- R8: The processor map (0x40 + index) is one-hot, with bit v meaning processor v. A write that does not have exactly one bit set is ignored. `vp_pend[v*NUM_SRC + s]` is set while source s is pending, enabled and mapped to processor v.
- R9: The pin map (0x60 + index) holds a delivery flag in bit31 and a pin number in the low bits. `irq_out[v*NUM_PIN + p]` is the OR over sources counted in processor v's vector whose flag is set and whose pin is p.
- R10: Address 0x00 reads {16'b0, P, N}, where N = NUM_SRC/8 - 1 and P = NUM_VP - 1, each eight bits wide.
- R11: Pending state reads as 32-bit words at 0x10 + word, with bit j of word k giving source 32k + j.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| irq_in | input | NUM_SRC | Asynchronous external interrupt lines |
| wr_en | input | 1 | Register write strobe |
| wr_addr | input | 8 | Register write address |
| wr_data | input | 32 | Register write data |
| rd_addr | input | 8 | Register read address |
| rd_data | output | 32 | Combinational read data |
| vp_pend | output | NUM_VP*NUM_SRC | Per-processor pending and enabled source vectors |
| irq_out | output | NUM_VP*NUM_PIN | Per-processor interrupt pins |

## Verification
A wrong latch or enable bit can show up at the ports in two ways. A stale latch shows as a pending bit that an acknowledge or a sense rewrite fails to drop, and it can be read back in the same cycle the command takes effect. A lost edge shows as a pending word that is still zero two to three clocks after the input transition. A wrong routing entry shows at once on `vp_pend` and `irq_out` in the wrong processor slot or on the wrong pin. The stimulus therefore reads back pending and enable words right after each command, and watches both output vectors after every routing change.

// File: rtl/shint_pkg.sv
package shint_pkg;

    typedef struct packed {
        logic both_edges;
        logic edge_mode;
        logic act_high;
    } sense_t;

    localparam sense_t SENSE_RST = '{both_edges: 1'b0, edge_mode: 1'b0, act_high: 1'b1};

    localparam logic [7:0] A_INFO     = 8'h00;
    localparam logic [7:0] A_EN_SET   = 8'h01;
    localparam logic [7:0] A_EN_CLR   = 8'h02;
    localparam logic [7:0] A_EDGE_CMD = 8'h03;
    localparam logic [7:0] B_PEND     = 8'h10;
    localparam logic [7:0] B_EN_RD    = 8'h18;
    localparam logic [7:0] B_SENSE    = 8'h20;
    localparam logic [7:0] B_VPMAP    = 8'h40;
    localparam logic [7:0] B_PINMAP   = 8'h60;

    function automatic logic edge_seen(sense_t s, logic now_v, logic prev_v);
        if (s.both_edges)
            return now_v ^ prev_v;
        else if (s.act_high)
            return now_v & ~prev_v;
        else
            return ~now_v & prev_v;
    endfunction

endpackage

// File: rtl/shint_sync.sv
module shint_sync #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] stage1;

    always_ff @(posedge clk) begin
        if (rst) begin
            stage1 <= '0;
            q      <= '0;
        end else begin
            stage1 <= d;
            q      <= stage1;
        end
    end
endmodule

// File: rtl/shint_src_cell.sv
module shint_src_cell
    import shint_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  sense_t sense,
    input  logic   line,
    input  logic   sw_set,
    input  logic   sw_clr,
    input  logic   sense_wr,
    output logic   pend
);
    logic line_prev;
    logic latch_q;
    logic hit;

    assign hit = edge_seen(sense, line, line_prev);

    always_ff @(posedge clk) begin
        if (rst) begin
            line_prev <= 1'b0;
            latch_q   <= 1'b0;
        end else begin
            line_prev <= line;
            if (sense_wr || !sense.edge_mode)
                latch_q <= 1'b0;
            else if (hit || sw_set)
                latch_q <= 1'b1;
            else if (sw_clr)
                latch_q <= 1'b0;
        end
    end

    assign pend = sense.edge_mode ? latch_q : (line ~^ sense.act_high);
endmodule

// File: rtl/shint_route.sv
module shint_route #(
    parameter int NUM_SRC = 16,
    parameter int NUM_VP  = 2,
    parameter int NUM_PIN = 4,
    parameter int PIN_W   = 2
) (
    input  logic [NUM_SRC-1:0]             active,
    input  logic [NUM_SRC-1:0][NUM_VP-1:0] vp_map,
    input  logic [NUM_SRC-1:0]             pin_en,
    input  logic [NUM_SRC-1:0][PIN_W-1:0]  pin_sel,
    output logic [NUM_VP*NUM_SRC-1:0]      vp_pend,
    output logic [NUM_VP*NUM_PIN-1:0]      irq_out
);
    for (genvar v = 0; v < NUM_VP; v++) begin : g_vp
        for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
            assign vp_pend[v*NUM_SRC + s] = active[s] & vp_map[s][v];
        end
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pin
            logic any;
            always_comb begin
                any = 1'b0;
                for (int s = 0; s < NUM_SRC; s++)
                    any = any | (vp_pend[v*NUM_SRC + s] & pin_en[s] &
                                 (pin_sel[s] == PIN_W'(p)));
            end
            assign irq_out[v*NUM_PIN + p] = any;
        end
    end
endmodule

// File: rtl/shint_ctrl.sv
module shint_ctrl
    import shint_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_VP  = 2,
    parameter int NUM_PIN = 4
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [NUM_SRC-1:0]        irq_in,
    input  logic                      wr_en,
    input  logic [7:0]                wr_addr,
    input  logic [31:0]               wr_data,
    input  logic [7:0]                rd_addr,
    output logic [31:0]               rd_data,
    output logic [NUM_VP*NUM_SRC-1:0] vp_pend,
    output logic [NUM_VP*NUM_PIN-1:0] irq_out
);
    localparam int PIN_W  = (NUM_PIN > 1) ? $clog2(NUM_PIN) : 1;
    localparam int NWORDS = (NUM_SRC + 31) / 32;
    localparam int PADW   = NWORDS * 32;

    sense_t [NUM_SRC-1:0]             sense_q;
    logic   [NUM_SRC-1:0]             en_q;
    logic   [NUM_SRC-1:0][NUM_VP-1:0] vpmap_q;
    logic   [NUM_SRC-1:0]             pin_en_q;
    logic   [NUM_SRC-1:0][PIN_W-1:0]  pinsel_q;

    logic [NUM_SRC-1:0] line_s;
    logic [NUM_SRC-1:0] pend_w;
    logic [NUM_SRC-1:0] edge_vec;
    logic [NUM_SRC-1:0] idx_hit;
    logic [NUM_SRC-1:0] sw_set;
    logic [NUM_SRC-1:0] sw_clr;
    logic [NUM_SRC-1:0] sense_wr;
    logic [PADW-1:0]    pend_pad;
    logic [PADW-1:0]    en_pad;

    shint_sync #(.W(NUM_SRC)) u_sync (
        .clk (clk),
        .rst (rst),
        .d   (irq_in),
        .q   (line_s)
    );

    for (genvar i = 0; i < NUM_SRC; i++) begin : g_cell
        assign idx_hit[i]  = (wr_data[30:0] == 31'(i));
        assign sw_set[i]   = wr_en && (wr_addr == A_EDGE_CMD) &&  wr_data[31] && idx_hit[i];
        assign sw_clr[i]   = wr_en && (wr_addr == A_EDGE_CMD) && !wr_data[31] && idx_hit[i];
        assign sense_wr[i] = wr_en && (wr_addr == B_SENSE + 8'(i));
        assign edge_vec[i] = sense_q[i].edge_mode;

        shint_src_cell u_cell (
            .clk      (clk),
            .rst      (rst),
            .sense    (sense_q[i]),
            .line     (line_s[i]),
            .sw_set   (sw_set[i]),
            .sw_clr   (sw_clr[i]),
            .sense_wr (sense_wr[i]),
            .pend     (pend_w[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                sense_q[i]  <= SENSE_RST;
                vpmap_q[i]  <= NUM_VP'(1);
                pinsel_q[i] <= '0;
            end
            en_q     <= '0;
            pin_en_q <= '0;
        end else if (wr_en) begin
            for (int i = 0; i < NUM_SRC; i++) begin
                if (wr_addr == A_EN_SET && idx_hit[i])
                    en_q[i] <= 1'b1;
                if (wr_addr == A_EN_CLR && idx_hit[i])
                    en_q[i] <= 1'b0;
                if (sense_wr[i])
                    sense_q[i] <= sense_t'(wr_data[2:0]);
                if (wr_addr == B_VPMAP + 8'(i) && $countones(wr_data[NUM_VP-1:0]) == 1)
                    vpmap_q[i] <= wr_data[NUM_VP-1:0];
                if (wr_addr == B_PINMAP + 8'(i)) begin
                    pin_en_q[i] <= wr_data[31];
                    pinsel_q[i] <= wr_data[PIN_W-1:0];
                end
            end
        end
    end

    shint_route #(
        .NUM_SRC (NUM_SRC),
        .NUM_VP  (NUM_VP),
        .NUM_PIN (NUM_PIN),
        .PIN_W   (PIN_W)
    ) u_route (
        .active  (pend_w & en_q),
        .vp_map  (vpmap_q),
        .pin_en  (pin_en_q),
        .pin_sel (pinsel_q),
        .vp_pend (vp_pend),
        .irq_out (irq_out)
    );

    assign pend_pad = PADW'(pend_w);
    assign en_pad   = PADW'(en_q);

    always_comb begin
        rd_data = '0;
        if (rd_addr == A_INFO)
            rd_data = {16'b0, 8'(NUM_VP - 1), 8'(NUM_SRC / 8 - 1)};
        for (int w = 0; w < NWORDS; w++) begin
            if (rd_addr == B_PEND + 8'(w))
                rd_data = pend_pad[w*32 +: 32];
            if (rd_addr == B_EN_RD + 8'(w))
                rd_data = en_pad[w*32 +: 32];
        end
        for (int i = 0; i < NUM_SRC; i++) begin
            if (rd_addr == B_SENSE + 8'(i))
                rd_data = 32'(sense_q[i]);
            if (rd_addr == B_VPMAP + 8'(i))
                rd_data = 32'(vpmap_q[i]);
            if (rd_addr == B_PINMAP + 8'(i))
                rd_data = {pin_en_q[i], 31'(pinsel_q[i])};
        end
    end
endmodule

// File: rtl/shint_ctrl_chk.sv
module shint_ctrl_chk
    import shint_pkg::*;
#(
    parameter int NUM_SRC = 16,
    parameter int NUM_VP  = 2,
    parameter int NUM_PIN = 4
) (
    input logic                      clk,
    input logic                      rst,
    input logic                      wr_en,
    input logic [7:0]                wr_addr,
    input logic [31:0]               wr_data,
    input logic [NUM_SRC-1:0]        en_bits,
    input logic [NUM_SRC-1:0]        pend_bits,
    input logic [NUM_SRC-1:0]        edge_bits,
    input logic [NUM_VP*NUM_SRC-1:0] vp_pend,
    input logic [NUM_VP*NUM_PIN-1:0] irq_out
);
    localparam int IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

    logic [IDX_W-1:0] widx;
    logic             idx_ok;
    assign widx   = wr_data[IDX_W-1:0];
    assign idx_ok = (wr_data[30:0] < 31'(NUM_SRC));

    // R1: outputs quiet right after reset
    p_quiet_after_reset_r1: assert property (@(posedge clk) disable iff (rst)
        $past(rst) |-> (vp_pend == '0 && irq_out == '0));

    // R7: an index written to the clear address drops that enable bit
    p_en_clear_r7: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_EN_CLR && idx_ok) |=> !en_bits[$past(widx)]);

    // R6: software edge on an edge source is pending next cycle
    p_sw_edge_r6: assert property (@(posedge clk) disable iff (rst)
        (wr_en && wr_addr == A_EDGE_CMD && wr_data[31] && idx_ok && edge_bits[widx])
        |=> pend_bits[$past(widx)]);

    for (genvar v = 0; v < NUM_VP; v++) begin : g_vchk
        // R7: disabled sources never reach a processor vector
        p_en_gate_r7: assert property (@(posedge clk) disable iff (rst)
            (vp_pend[v*NUM_SRC +: NUM_SRC] & ~en_bits) == '0);
        for (genvar p = 0; p < NUM_PIN; p++) begin : g_pchk
            // R9: a pin only fires when its processor has something pending
            p_pin_needs_pend_r9: assert property (@(posedge clk) disable iff (rst)
                irq_out[v*NUM_PIN + p] |-> (|vp_pend[v*NUM_SRC +: NUM_SRC]));
        end
    end
endmodule

bind shint_ctrl shint_ctrl_chk #(
    .NUM_SRC (NUM_SRC),
    .NUM_VP  (NUM_VP),
    .NUM_PIN (NUM_PIN)
) u_chk (
    .clk       (clk),
    .rst       (rst),
    .wr_en     (wr_en),
    .wr_addr   (wr_addr),
    .wr_data   (wr_data),
    .en_bits   (en_q),
    .pend_bits (pend_w),
    .edge_bits (edge_vec),
    .vp_pend   (vp_pend),
    .irq_out   (irq_out)
);

// File: tb/shint_ctrl_tb.sv
module shint_ctrl_tb;
    localparam int NS = 16;
    localparam int NV = 2;
    localparam int NP = 4;

    logic              clk = 1'b0;
    logic              rst = 1'b1;
    logic [NS-1:0]     irq_in = '0;
    logic              wr_en = 1'b0;
    logic [7:0]        wr_addr = '0;
    logic [31:0]       wr_data = '0;
    logic [7:0]        rd_addr = '0;
    logic [31:0]       rd_data;
    logic [NV*NS-1:0]  vp_pend;
    logic [NV*NP-1:0]  irq_out;

    int n_cmp = 0;
    int n_bad = 0;

    always #5 clk = ~clk;

    shint_ctrl #(.NUM_SRC(NS), .NUM_VP(NV), .NUM_PIN(NP)) u_dut (
        .clk (clk), .rst (rst), .irq_in (irq_in),
        .wr_en (wr_en), .wr_addr (wr_addr), .wr_data (wr_data),
        .rd_addr (rd_addr), .rd_data (rd_data),
        .vp_pend (vp_pend), .irq_out (irq_out)
    );

    // entry: [5:3] sense {both,edge,high}, [2] input before, [1] input after, [0] expected pending
    localparam logic [5:0] VEC [0:10] = '{
        6'b001_01_1, 6'b001_10_0,   // level high
        6'b000_10_1, 6'b000_01_0,   // level low
        6'b011_01_1, 6'b011_10_0,   // rising edge
        6'b010_10_1, 6'b010_01_0,   // falling edge
        6'b111_10_1, 6'b110_01_1,   // both edges
        6'b111_00_0                 // both edges, no transition
    };

    task automatic idle(input int n);
        for (int i = 0; i < n; i++) @(negedge clk);
    endtask

    task automatic wr(input logic [7:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0; wr_addr = '0; wr_data = '0;
    endtask

    task automatic rd(input logic [7:0] a, output logic [31:0] d);
        rd_addr = a;
        #1;
        d = rd_data;
    endtask

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        n_cmp++;
        if (act !== exp) begin
            n_bad++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_bad++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin
        logic [31:0] r;
        idle(4);
        rst = 1'b0;
        idle(1);

        // R1 reset state
        rd(8'h10, r); chk("R1 pend", r, 32'h0);
        rd(8'h18, r); chk("R1 enable", r, 32'h0);
        rd(8'h20, r); chk("R1 sense", r, 32'h1);
        rd(8'h40, r); chk("R1 vpmap", r, 32'h1);
        chk("R1 vp_pend", 32'(vp_pend), 32'h0);
        chk("R1 irq_out", 32'(irq_out), 32'h0);

        // R10 info word
        rd(8'h00, r); chk("R10 info", r, 32'h0000_0101);

        // R2 R3 R4 sense table on source 3
        for (int k = 0; k < 11; k++) begin
            logic [5:0] e;
            string tag;
            e = VEC[k];
            tag = !e[4] ? "R2" : (e[5] ? "R4" : "R3");
            irq_in[3] = e[2];
            idle(4);
            wr(8'h23, {29'b0, e[5:3]});
            idle(2);
            irq_in[3] = e[1];
            idle(4);
            rd(8'h10, r);
            chk(tag, 32'(r[3]), 32'(e[0]));
        end
        wr(8'h23, 32'h1);

        // R7 enable set/clear by index
        wr(8'h01, 32'd5);  rd(8'h18, r); chk("R7 set 5", r, 32'h0020);
        wr(8'h01, 32'd9);  rd(8'h18, r); chk("R7 set 9", r, 32'h0220);
        wr(8'h02, 32'd5);  rd(8'h18, r); chk("R7 clr 5", r, 32'h0200);
        wr(8'h01, 32'd20); rd(8'h18, r); chk("R7 out of range", r, 32'h0200);
        wr(8'h02, 32'd9);  rd(8'h18, r); chk("R7 clr 9", r, 32'h0000);

        // R8 R9 routing of source 5 to processor 1, pin 2
        irq_in[5] = 1'b1;
        wr(8'h01, 32'd5);
        wr(8'h45, 32'h2);
        wr(8'h65, 32'h8000_0002);
        idle(3);
        chk("R8 vp1 slot", 32'(vp_pend[NS + 5]), 32'h1);
        chk("R8 vp0 slot", 32'(vp_pend[5]), 32'h0);
        chk("R9 pin", 32'(irq_out), 32'h40);
        wr(8'h45, 32'h3);
        idle(1);
        chk("R8 non-onehot ignored", 32'(vp_pend[NS + 5]), 32'h1);
        wr(8'h65, 32'h2);
        idle(1);
        chk("R9 flag off", 32'(irq_out), 32'h0);
        chk("R9 vector kept", 32'(vp_pend[NS + 5]), 32'h1);
        wr(8'h02, 32'd5);
        idle(1);
        chk("R7 disabled hidden", 32'(vp_pend), 32'h0);
        irq_in[5] = 1'b0;

        // R6 R5 software edge and acknowledge on source 7
        wr(8'h27, 32'h3);
        idle(2);
        wr(8'h03, 32'h8000_0007);
        rd(8'h10, r); chk("R6 sw edge", 32'(r[7]), 32'h1);
        wr(8'h03, 32'h0000_0007);
        rd(8'h10, r); chk("R5 ack", 32'(r[7]), 32'h0);
        irq_in[7] = 1'b1; idle(4);
        irq_in[7] = 1'b0; idle(4);
        rd(8'h10, r); chk("R3 latch held", 32'(r[7]), 32'h1);
        wr(8'h03, 32'h0000_0007);
        rd(8'h10, r); chk("R5 ack after edge", 32'(r[7]), 32'h0);

        // R6 software edge ignored on a level source
        wr(8'h03, 32'h8000_0008);
        idle(1);
        rd(8'h10, r); chk("R6 level ignores", 32'(r[8]), 32'h0);

        // R11 word layout
        wr(8'h2C, 32'h0);
        idle(3);
        rd(8'h10, r); chk("R11 word", r, 32'h0000_1000);

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule